// File: doc/BRIEF.md
# Beam-Synchronous Front-End Power Cycle Controller

This block sequences the supply and acquisition windows of a string of front-end readout chips. These chips are only switched on around the beam, which cuts their average dissipation. The block repeats a fixed period. At the start of each period it raises a power-enable output. While the front end is powered, it opens an acquisition window for an opening stretch. It accepts a qualified external trigger. After a trigger it walks the daisy chain of chips, one chip after another, to read them out. It keeps a busy output high until that walk ends or a maximum readout time runs out. For the rest of the period it stays idle.

A test mode fires a single-cycle charge-injection strobe at a programmable offset from the start of the powered window. This lets the bench or a calibration run probe the front end at any point inside that window. Two sticky flags record abnormal events. One marks a trigger that was dropped because it came outside the acquisition window. The other marks a period start that had to be delayed because readout was still running. Every duration is a count of system clock cycles set by a parameter. The defaults describe a 10 ms period with a 2 ms powered window at 100 MHz.

Top module: `pulse_cycle_ctrl`

## Requirements
- R1: The first period begins on the first clock edge at which reset is low. From then on, `pwr_en_o` is high for the first ON_CYC cycles of every PERIOD_CYC-cycle period and low for the remaining cycles.
- R2: `acq_en_o` is high only during the first ACQ_CYC cycles of a period and only while `busy_o` is low. It is never high while `pwr_en_o` is low.
- R3: A trigger is accepted at a clock edge only if all four of these hold at that edge: `coinc_i` is high, `spill_i` is high, `veto_i` is low and `acq_en_o` is high. After an accepted trigger, `busy_o` is high in the following cycle. An unaccepted trigger leaves `busy_o` low.
- R4: Readout starts at chip index 0 on `rd_chip_o`. Each cycle in which `chip_done_i` is high during readout advances the index by one. A done from chip N_CHIPS-1 ends readout, and `busy_o` is low in the next cycle.
- R5: `busy_o` never stays high for more than RO_MAX_CYC consecutive cycles. If no chip-done pulses arrive, it stays high for exactly RO_MAX_CYC cycles.
- R6: `trig_drop_o` sets, and stays set until reset, when `coinc_i`, `spill_i` and `!veto_i` are all true while `acq_en_o` is low. A trigger that is gated off only by `veto_i` or by a low `spill_i` does not set it.
- R7: While `test_mode_i` is high, `inj_o` pulses high for exactly one cycle per period, at offset `inj_dly_i` from the period start. This happens only when 1 <= `inj_dly_i` < ON_CYC. Outside that range, or when test mode is low, `inj_o` stays low.
- R8: A period boundary can be reached while `busy_o` is high. In that case power stays off, `overrun_o` sets and stays set until reset, and the new period begins on the first edge at which `busy_o` is low. As a result, `pwr_en_o` rises one cycle after `busy_o` falls.
- R9: While the synchronous active-high reset is high, every output is low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| coinc_i | input | 1 | External trigger (scintillator coincidence) |
| spill_i | input | 1 | Beam in-spill qualifier |
| veto_i | input | 1 | Trigger veto |
| chip_done_i | input | 1 | Current chip of the chain has finished its readout |
| test_mode_i | input | 1 | Enables the charge-injection strobe |
| inj_dly_i | input | PW | Strobe offset from the start of the period, in cycles |
| pwr_en_o | output | 1 | Front-end power enable |
| acq_en_o | output | 1 | Acquisition window enable |
| busy_o | output | 1 | Readout in progress |
| rd_chip_o | output | CHW | Index of the chip being read |
| inj_o | output | 1 | Charge-injection strobe |
| trig_drop_o | output | 1 | Sticky: trigger arrived outside the window |
| overrun_o | output | 1 | Sticky: period start was held off by readout |

## Verification
Power, acquisition and strobe outputs are decoded from the registered period position. Their expected values therefore follow arithmetically from the number of edges since reset released: after the k-th edge the position is (k-1) mod PERIOD_CYC. The bench keeps that position itself and compares on every falling edge. A trigger or chip-done input is driven just after a falling edge and is registered at the next rising edge. Its effect on `busy_o`, `rd_chip_o` and the flags is checked one falling edge later. The timeout is measured by counting falling-edge samples of `busy_o`. The held-off period is checked on the sample where busy has just dropped, when power must still be low, and on the following sample, when it must be high.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WALK = 1'b1
    } rd_ph_t;
endpackage

// File: rtl/pp_period.sv
module pp_period #(
    parameter int PERIOD_CYC = 1000000,
    parameter int PW         = $clog2(PERIOD_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    output logic          run_o,
    output logic [PW-1:0] per_o,
    output logic          ovr_o
);
    typedef struct packed {
        logic          run;
        logic          ovr;
        logic [PW-1:0] per;
    } per_st_t;

    localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);

    per_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            // waiting at a period boundary: start only when readout is idle
            if (!busy_i) begin
                st_d.run = 1'b1;
                st_d.per = '0;
            end
        end else if (st_q.per == LAST) begin
            st_d.per = '0;
            if (busy_i) begin
                st_d.run = 1'b0;
                st_d.ovr = 1'b1;
            end
        end else begin
            st_d.per = st_q.per + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign run_o = st_q.run;
    assign per_o = st_q.per;
    assign ovr_o = st_q.ovr;

    // R1
    per_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.per <= LAST);
    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(st_q.ovr) |-> st_q.ovr);
    // R8
    hold_enter_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.run) |-> $past(busy_i));
endmodule

// File: rtl/pp_readout.sv
module pp_readout #(
    parameter int N_CHIPS    = 24,
    parameter int RO_MAX_CYC = 400000,
    parameter int CHW        = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trig_ok_i,
    input  logic           chip_done_i,
    output logic           busy_o,
    output logic [CHW-1:0] chip_o
);
    import pp_pkg::*;

    localparam int TW = $clog2(RO_MAX_CYC + 1);
    localparam logic [TW-1:0]  TMR_END  = TW'(RO_MAX_CYC - 1);
    localparam logic [CHW-1:0] CHIP_END = CHW'(N_CHIPS - 1);

    typedef struct packed {
        rd_ph_t         ph;
        logic [CHW-1:0] chip;
        logic [TW-1:0]  tmr;
    } ro_st_t;

    ro_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            RD_IDLE: begin
                if (trig_ok_i) begin
                    st_d.ph   = RD_WALK;
                    st_d.chip = '0;
                    st_d.tmr  = '0;
                end
            end
            RD_WALK: begin
                st_d.tmr = st_q.tmr + 1'b1;
                if (st_q.tmr == TMR_END) begin
                    st_d.ph = RD_IDLE;
                end else if (chip_done_i) begin
                    if (st_q.chip == CHIP_END) st_d.ph   = RD_IDLE;
                    else                       st_d.chip = st_q.chip + 1'b1;
                end
            end
            default: st_d.ph = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o = (st_q.ph == RD_WALK);
    assign chip_o = st_q.chip;

    // R4
    chip_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.chip <= CHIP_END);
    // R5
    ro_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> st_q.tmr <= TMR_END);
    // R4
    walk_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (st_q.chip == '0 && $past(trig_ok_i)));
endmodule

// File: rtl/pulse_cycle_ctrl.sv
module pulse_cycle_ctrl #(
    parameter int PERIOD_CYC = 1000000,
    parameter int ON_CYC     = 200000,
    parameter int ACQ_CYC    = 100000,
    parameter int RO_MAX_CYC = 400000,
    parameter int N_CHIPS    = 24,
    parameter int PW         = $clog2(PERIOD_CYC),
    parameter int CHW        = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           coinc_i,
    input  logic           spill_i,
    input  logic           veto_i,
    input  logic           chip_done_i,
    input  logic           test_mode_i,
    input  logic [PW-1:0]  inj_dly_i,
    output logic           pwr_en_o,
    output logic           acq_en_o,
    output logic           busy_o,
    output logic [CHW-1:0] rd_chip_o,
    output logic           inj_o,
    output logic           trig_drop_o,
    output logic           overrun_o
);
    localparam logic [PW-1:0] ON_LIM  = PW'(ON_CYC);
    localparam logic [PW-1:0] ACQ_LIM = PW'(ACQ_CYC);

    typedef struct packed {
        logic drop;
    } top_st_t;

    logic          run;
    logic [PW-1:0] per;
    logic          ovr;
    logic          busy;
    logic          qual;
    logic          trig_ok;
    logic          dly_ok;
    top_st_t       st_q, st_d;

    pp_period #(.PERIOD_CYC(PERIOD_CYC), .PW(PW)) u_period (
        .clk(clk), .rst(rst), .busy_i(busy),
        .run_o(run), .per_o(per), .ovr_o(ovr)
    );

    pp_readout #(.N_CHIPS(N_CHIPS), .RO_MAX_CYC(RO_MAX_CYC), .CHW(CHW)) u_readout (
        .clk(clk), .rst(rst), .trig_ok_i(trig_ok), .chip_done_i(chip_done_i),
        .busy_o(busy), .chip_o(rd_chip_o)
    );

    always_comb begin
        pwr_en_o = run && (per < ON_LIM);
        acq_en_o = run && (per < ACQ_LIM) && !busy;
        qual     = coinc_i && spill_i && !veto_i;
        trig_ok  = qual && acq_en_o;
        dly_ok   = (inj_dly_i != '0) && (inj_dly_i < ON_LIM);
        inj_o    = run && test_mode_i && dly_ok && (per == inj_dly_i);
        st_d     = st_q;
        if (qual && !acq_en_o) st_d.drop = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o      = busy;
    assign trig_drop_o = st_q.drop;
    assign overrun_o   = ovr;

    // R2
    acq_in_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        acq_en_o |-> pwr_en_o);
    // R7
    inj_in_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        inj_o |-> pwr_en_o);
    // R3
    trig_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(coinc_i && spill_i && !veto_i));
    // R6
    drop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(trig_drop_o) |-> trig_drop_o);
    // R8
    hold_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !$past(overrun_o)) |-> !pwr_en_o);
endmodule

// File: tb/sim_pulse_cycle_ctrl.sv
module sim_pulse_cycle_ctrl;
    localparam int P   = 40;
    localparam int ON  = 12;
    localparam int ACQ = 6;
    localparam int ROM = 48;
    localparam int NC  = 3;
    localparam int PW  = $clog2(P);
    localparam int CHW = $clog2(NC);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coinc = 1'b0, spill = 1'b0, veto = 1'b0, done = 1'b0, tmode = 1'b0;
    logic [PW-1:0] dly = '0;
    logic pwr, acq, busy, inj, drop, ovr;
    logic [CHW-1:0] chip;

    int checks = 0;
    int errors = 0;
    int per_m  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pulse_cycle_ctrl #(.PERIOD_CYC(P), .ON_CYC(ON), .ACQ_CYC(ACQ),
                       .RO_MAX_CYC(ROM), .N_CHIPS(NC)) u0 (
        .clk(clk), .rst(rst), .coinc_i(coinc), .spill_i(spill), .veto_i(veto),
        .chip_done_i(done), .test_mode_i(tmode), .inj_dly_i(dly),
        .pwr_en_o(pwr), .acq_en_o(acq), .busy_o(busy), .rd_chip_o(chip),
        .inj_o(inj), .trig_drop_o(drop), .overrun_o(ovr)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (pos %0d)", req, act, exp, per_m);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        per_m = (per_m + 1) % P;
    endtask

    task automatic wait_pos(input int pos);
        while (per_m != pos) step();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        int hits;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 pwr", pwr, 0); check("R9 acq", acq, 0); check("R9 busy", busy, 0);
        check("R9 inj", inj, 0); check("R9 drop", drop, 0); check("R9 ovr", ovr, 0);
        rst = 1'b0;
        per_m = -1;
        step();

        // R1 R2: two idle periods, no triggers, no test mode
        for (int c = 0; c < 2 * P; c++) begin
            check("R1 pwr window", pwr, int'(per_m < ON));
            check("R2 acq window", acq, int'(per_m < ACQ));
            check("R7 inj off", inj, 0);
            step();
        end

        // R7: sweep strobe offset, including 0 and ON (out of range)
        tmode = 1'b1;
        for (int d = 0; d <= ON; d++) begin
            wait_pos(P - 1);
            dly = PW'(d);
            step();
            hits = 0;
            for (int c = 0; c < P; c++) begin
                check("R7 inj position", inj,
                      int'(per_m == d && d >= 1 && d < ON));
                hits += int'(inj);
                step();
            end
            check("R7 strobe count", hits, int'(d >= 1 && d < ON));
        end
        tmode = 1'b0;

        // R3: vetoed and out-of-spill triggers are not accepted
        wait_pos(1);
        coinc = 1'b1; spill = 1'b1; veto = 1'b1;
        step();
        check("R3 veto blocks", busy, 0);
        veto = 1'b0; spill = 1'b0;
        step();
        check("R3 spill blocks", busy, 0);
        check("R6 no drop on gated", drop, 0);
        // R3: qualified trigger in window
        spill = 1'b1;
        step();
        check("R3 accepted", busy, 1);
        check("R2 acq low while busy", acq, 0);
        check("R4 start chip", int'(chip), 0);
        coinc = 1'b0;
        // R4: walk the chain
        for (int c = 0; c < NC; c++) begin
            check("R4 chip index", int'(chip), c);
            done = 1'b1;
            step();
            done = 1'b0;
        end
        check("R4 busy ends after last chip", busy, 0);
        check("R2 acq back", acq, int'(per_m < ACQ));

        // R6: trigger after the window sets the sticky drop flag
        wait_pos(ACQ + 2);
        coinc = 1'b1;
        step();
        coinc = 1'b0;
        check("R6 no accept outside", busy, 0);
        check("R6 drop set", drop, 1);
        step();
        check("R6 drop sticky", drop, 1);

        // R5 R8: unanswered readout times out and overruns the period
        check("R8 no overrun yet", ovr, 0);
        wait_pos(ACQ - 1);
        coinc = 1'b1;
        step();
        coinc = 1'b0;
        n = 0;
        while (busy && n < 4 * ROM) begin
            n++;
            step();
        end
        check("R5 timeout length", n, ROM);
        check("R8 overrun set", ovr, 1);
        check("R8 power held off", pwr, 0);
        step();
        check("R8 power after busy", pwr, 1);
        per_m = 0;
        for (int c = 0; c < ON; c++) step();
        check("R1 window after hold", pwr, 0);
        check("R8 overrun sticky", ovr, 1);

        // R9: reset in the middle of a readout
        wait_pos(2);
        coinc = 1'b1;
        step();
        coinc = 1'b0;
        check("R3 accepted again", busy, 1);
        rst = 1'b1;
        step();
        check("R9 busy", busy, 0); check("R9 pwr", pwr, 0);
        check("R9 drop", drop, 0); check("R9 ovr", ovr, 0);
        check("R9 chip", int'(chip), 0);
        summary();
    end
endmodule